// File: doc/BRIEF.md
# USB Endpoint Stall Handshake Controller

This block holds the halt state of a USB device's endpoints and chooses the handshake for every transaction the serial engine reports. Each bulk endpoint has two independent halt flags, one for its IN direction and one for its OUT direction. The bidirectional control endpoint zero has a single flag that serves both directions. Firmware reaches the flags through a small register port. The host reaches them through decoded standard requests: set halt, clear halt and endpoint status.

For each transaction the block answers with ACK, NAK or STALL, given as a 4-bit PID with a valid strobe. Isochronous transactions and transactions to endpoints that do not exist get no handshake. A halted bulk endpoint stays halted until it is cleared explicitly. The endpoint zero flag drops by itself once a transaction has been answered with STALL, so the next control request is not locked out. When a bulk endpoint's halt is cleared by a host request, the block also sends a one-cycle pulse that resets that endpoint's data toggle.

Top module: `usb_stall_ctrl`

## Requirements
- R1: After a synchronous reset all halt flags are clear, and `hs_valid`, `hs_pid`, `sts_valid`, `sts_byte0`, `sts_byte1`, `tgl_clr` and `cpu_rdata` are all zero.
- R2: A register address is {dir, ep}, where bit 4 = 1 selects IN and bits 3:0 give the endpoint number; for endpoint 0 the direction bit is ignored. When `cpu_wr` is high, `cpu_wstall` is stored into that flag. `cpu_rdata` is registered and, one cycle after an address is presented, shows the flag in bit 0 with bits 7:1 zero. Addresses with an endpoint number of NUM_EP or more read as zero, and writes to them change no flag.
- R3: One cycle after `tx_valid`, for a non-isochronous transaction to an existing endpoint, `hs_valid` is 1 and `hs_pid` is STALL (4'b1110) if the selected flag is set. Otherwise it is ACK (4'b0010) when `tx_ready` is 1, and NAK (4'b1010) when it is 0. `hs_pid` is zero whenever `hs_valid` is 0. The `tx_type` codes are 00 control, 01 isochronous, 10 bulk and 11 interrupt.
- R4: One cycle after an isochronous transaction (`tx_type` 01), `hs_valid` is 0 whatever the flag state, and no flag changes because of it.
- R5: Endpoint 0 uses one flag for both directions. A non-isochronous endpoint 0 transaction that is answered with STALL clears that flag at the same edge, so the following endpoint 0 transaction gets ACK or NAK.
- R6: The IN and OUT flags of a bulk endpoint are independent, and a set bulk flag stays set across any number of transactions until the CPU or a clear-halt request clears it.
- R7: With `req_valid` high, `req_code` 01 (set halt) sets, and `req_code` 10 (clear halt) clears, the flag of the endpoint named by `req_index`. In `req_index`, bit 7 = 1 means IN and bits 3:0 give the endpoint number. An index whose bits 6:4 are non-zero, or whose endpoint number is NUM_EP or more, changes no flag.
- R8: A clear-halt request to an existing bulk endpoint n (n ≥ 1) raises `tgl_clr` bit n-1, and only that bit, for exactly one cycle, one cycle after the request. Set-halt requests and requests for endpoint 0 raise no bit.
- R9: A status request (`req_code` 11) raises `sts_valid` one cycle later. `sts_byte0` bit 0 then holds the flag as it was in the request cycle, before any change made in that cycle, and every other bit of both bytes is zero. An unknown endpoint reads back as zero.
- R10: When a CPU write and a host request or the endpoint 0 self-clear change the same flag in one cycle, the CPU value wins. A set-halt request on endpoint 0 wins over that endpoint's self-clear.
- R11: A transaction to an endpoint number of NUM_EP or more gets no handshake (`hs_valid` 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | EP_W+1 | Register address {dir, endpoint} |
| cpu_wstall | input | 1 | Halt value written (register bit 0) |
| cpu_rdata | output | 8 | Registered read-back of the addressed register |
| req_valid | input | 1 | Decoded standard request present |
| req_code | input | 2 | 01 set halt, 10 clear halt, 11 status |
| req_index | input | 8 | Request index byte (bit 7 = IN) |
| sts_valid | output | 1 | Status reply valid |
| sts_byte0 | output | 8 | Status reply first byte (bit 0 = halted) |
| sts_byte1 | output | 8 | Status reply second byte (zero) |
| tgl_clr | output | NUM_EP-1 | Data-toggle reset pulse, bit n-1 for endpoint n |
| tx_valid | input | 1 | Transaction present |
| tx_ep | input | EP_W | Transaction endpoint number |
| tx_dir | input | 1 | Transaction direction, 1 = IN |
| tx_type | input | 2 | Transfer type code |
| tx_ready | input | 1 | Endpoint buffer ready |
| hs_valid | output | 1 | Handshake to be sent |
| hs_pid | output | 4 | Handshake PID |

## Verification
The handshake path is driven with every combination of flag state, buffer readiness, transfer type and direction, over both existing and missing endpoint numbers. The ACK/NAK/STALL split shows whether the flag or the buffer state was chosen, and isochronous or missing endpoints show whether the handshake is suppressed. Directed sequences separate the persistent bulk flags from the self-clearing endpoint 0 flag by sending repeated transactions after a stall. They also place a CPU write and a host request on the same flag in one cycle, to show which one wins. The random phase also mixes set, clear and status requests with transactions, and the status replies and read-backs expose flags the handshakes never touched.

// File: rtl/usb_stall_pkg.sv
package usb_stall_pkg;

  typedef enum logic [1:0] {
    XT_CTRL = 2'b00,
    XT_ISO  = 2'b01,
    XT_BULK = 2'b10,
    XT_INTR = 2'b11
  } xfer_t;

  typedef enum logic [1:0] {
    RQ_NONE     = 2'b00,
    RQ_SET_HALT = 2'b01,
    RQ_CLR_HALT = 2'b10,
    RQ_GET_STAT = 2'b11
  } req_t;

  localparam logic [3:0] PID_ACK   = 4'b0010;
  localparam logic [3:0] PID_NAK   = 4'b1010;
  localparam logic [3:0] PID_STALL = 4'b1110;

  // flag layout: 0 = endpoint zero, 1..nb = OUT ep, nb+1..2nb = IN ep
  function automatic int flag_index(input int ep, input logic dir, input int nb);
    if (ep == 0) return 0;
    else if (dir) return nb + ep;
    else return ep;
  endfunction

endpackage

// File: rtl/stall_flag_bank.sv
module stall_flag_bank
  import usb_stall_pkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int EP_W   = 4,
  localparam int NB    = NUM_EP - 1,
  localparam int NF    = 2 * NB + 1,
  localparam int IDX_W = $clog2(NF)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_wr,
  input  logic [EP_W:0]   cpu_addr,
  input  logic            cpu_wstall,
  input  logic [NF-1:0]   set_vec,
  input  logic [NF-1:0]   clr_vec,
  output logic [NF-1:0]   flags,
  output logic [7:0]      cpu_rdata
);

  logic             cpu_known;
  logic [IDX_W-1:0] cpu_idx;
  logic [NF-1:0]    cpu_hit;

  always_comb begin
    cpu_known = int'(cpu_addr[EP_W-1:0]) < NUM_EP;
    cpu_idx   = IDX_W'(flag_index(int'(cpu_addr[EP_W-1:0]), cpu_addr[EP_W], NB));
  end

  for (genvar f = 0; f < NF; f++) begin : g_flag
    assign cpu_hit[f] = cpu_wr && cpu_known && (int'(cpu_idx) == f);

    always_ff @(posedge clk) begin
      if (rst)               flags[f] <= 1'b0;
      else if (cpu_hit[f])   flags[f] <= cpu_wstall;
      else if (set_vec[f])   flags[f] <= 1'b1;
      else if (clr_vec[f])   flags[f] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            cpu_rdata <= 8'h00;
    else if (cpu_known) cpu_rdata <= {7'b0, flags[cpu_idx]};
    else                cpu_rdata <= 8'h00;
  end

endmodule

// File: rtl/stall_hs_sel.sv
module stall_hs_sel
  import usb_stall_pkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int EP_W   = 4,
  localparam int NB    = NUM_EP - 1,
  localparam int NF    = 2 * NB + 1,
  localparam int IDX_W = $clog2(NF)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tx_valid,
  input  logic [EP_W-1:0] tx_ep,
  input  logic            tx_dir,
  input  logic [1:0]      tx_type,
  input  logic            tx_ready,
  input  logic [NF-1:0]   flags,
  output logic            ep0_clr,
  output logic            hs_valid,
  output logic [3:0]      hs_pid
);

  logic             known;
  logic             answer;
  logic             halted;
  logic [IDX_W-1:0] idx;
  logic [3:0]       pid_nxt;

  always_comb begin
    known   = int'(tx_ep) < NUM_EP;
    idx     = IDX_W'(flag_index(int'(tx_ep), tx_dir, NB));
    answer  = tx_valid && known && (xfer_t'(tx_type) != XT_ISO);
    halted  = flags[idx];
    if (halted)        pid_nxt = PID_STALL;
    else if (tx_ready) pid_nxt = PID_ACK;
    else               pid_nxt = PID_NAK;
    ep0_clr = answer && halted && (idx == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_valid <= 1'b0;
      hs_pid   <= 4'h0;
    end else begin
      hs_valid <= answer;
      hs_pid   <= answer ? pid_nxt : 4'h0;
    end
  end

endmodule

// File: rtl/stall_req_ctl.sv
module stall_req_ctl
  import usb_stall_pkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int EP_W   = 4,
  localparam int NB    = NUM_EP - 1,
  localparam int NF    = 2 * NB + 1,
  localparam int IDX_W = $clog2(NF)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_code,
  input  logic [7:0]    req_index,
  input  logic [NF-1:0] flags,
  output logic [NF-1:0] set_vec,
  output logic [NF-1:0] clr_vec,
  output logic          sts_valid,
  output logic [7:0]    sts_byte0,
  output logic [7:0]    sts_byte1,
  output logic [NB-1:0] tgl_clr
);

  logic             known;
  logic [EP_W-1:0]  ep;
  logic [IDX_W-1:0] idx;
  req_t             code;
  logic [NB-1:0]    tgl_nxt;

  always_comb begin
    ep    = req_index[EP_W-1:0];
    known = ((req_index[6:0] >> EP_W) == 7'd0) && (int'(ep) < NUM_EP);
    idx   = IDX_W'(flag_index(int'(ep), req_index[7], NB));
    code  = req_t'(req_code);
  end

  for (genvar f = 0; f < NF; f++) begin : g_dec
    assign set_vec[f] = req_valid && known && (code == RQ_SET_HALT) && (int'(idx) == f);
    assign clr_vec[f] = req_valid && known && (code == RQ_CLR_HALT) && (int'(idx) == f);
  end

  for (genvar n = 0; n < NB; n++) begin : g_tgl
    assign tgl_nxt[n] = req_valid && known && (code == RQ_CLR_HALT) && (int'(ep) == n + 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_valid <= 1'b0;
      sts_byte0 <= 8'h00;
      sts_byte1 <= 8'h00;
      tgl_clr   <= '0;
    end else begin
      sts_valid <= req_valid && (code == RQ_GET_STAT);
      sts_byte0 <= (req_valid && (code == RQ_GET_STAT) && known) ? {7'b0, flags[idx]} : 8'h00;
      sts_byte1 <= 8'h00;
      tgl_clr   <= tgl_nxt;
    end
  end

endmodule

// File: rtl/usb_stall_ctrl.sv
module usb_stall_ctrl
  import usb_stall_pkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int EP_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [EP_W:0]     cpu_addr,
  input  logic              cpu_wstall,
  output logic [7:0]        cpu_rdata,
  input  logic              req_valid,
  input  logic [1:0]        req_code,
  input  logic [7:0]        req_index,
  output logic              sts_valid,
  output logic [7:0]        sts_byte0,
  output logic [7:0]        sts_byte1,
  output logic [NUM_EP-2:0] tgl_clr,
  input  logic              tx_valid,
  input  logic [EP_W-1:0]   tx_ep,
  input  logic              tx_dir,
  input  logic [1:0]        tx_type,
  input  logic              tx_ready,
  output logic              hs_valid,
  output logic [3:0]        hs_pid
);

  localparam int NB = NUM_EP - 1;
  localparam int NF = 2 * NB + 1;

  logic [NF-1:0] flags;
  logic [NF-1:0] req_set;
  logic [NF-1:0] req_clr;
  logic [NF-1:0] clr_all;
  logic          ep0_clr;

  assign clr_all = req_clr | {{(NF-1){1'b0}}, ep0_clr};

  stall_flag_bank #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_bank (
    .clk(clk), .rst(rst),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wstall(cpu_wstall),
    .set_vec(req_set), .clr_vec(clr_all),
    .flags(flags), .cpu_rdata(cpu_rdata)
  );

  stall_req_ctl #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_req (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_code(req_code), .req_index(req_index),
    .flags(flags), .set_vec(req_set), .clr_vec(req_clr),
    .sts_valid(sts_valid), .sts_byte0(sts_byte0), .sts_byte1(sts_byte1),
    .tgl_clr(tgl_clr)
  );

  stall_hs_sel #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_hs (
    .clk(clk), .rst(rst),
    .tx_valid(tx_valid), .tx_ep(tx_ep), .tx_dir(tx_dir),
    .tx_type(tx_type), .tx_ready(tx_ready), .flags(flags),
    .ep0_clr(ep0_clr), .hs_valid(hs_valid), .hs_pid(hs_pid)
  );

endmodule

// File: rtl/usb_stall_ctrl_chk.sv
module usb_stall_ctrl_chk
  import usb_stall_pkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int EP_W   = 4,
  localparam int NB    = NUM_EP - 1,
  localparam int NF    = 2 * NB + 1,
  localparam int IDX_W = $clog2(NF)
) (
  input logic            clk,
  input logic            rst,
  input logic            cpu_wr,
  input logic [EP_W:0]   cpu_addr,
  input logic            cpu_wstall,
  input logic            req_valid,
  input logic [1:0]      req_code,
  input logic [7:0]      req_index,
  input logic            sts_valid,
  input logic [NB-1:0]   tgl_clr,
  input logic            tx_valid,
  input logic [EP_W-1:0] tx_ep,
  input logic            tx_dir,
  input logic [1:0]      tx_type,
  input logic            hs_valid,
  input logic [3:0]      hs_pid,
  input logic [NF-1:0]   flags
);

  logic [IDX_W-1:0] t_idx;
  logic [IDX_W-1:0] c_idx;
  logic             t_live;
  logic             c_known;
  logic             cpu_ep0;
  logic             set_ep0;

  always_comb begin
    t_idx   = IDX_W'(flag_index(int'(tx_ep), tx_dir, NB));
    c_idx   = IDX_W'(flag_index(int'(cpu_addr[EP_W-1:0]), cpu_addr[EP_W], NB));
    t_live  = tx_valid && (int'(tx_ep) < NUM_EP) && (tx_type != 2'b01);
    c_known = int'(cpu_addr[EP_W-1:0]) < NUM_EP;
    cpu_ep0 = cpu_wr && (cpu_addr[EP_W-1:0] == '0);
    set_ep0 = req_valid && (req_code == 2'b01) && (req_index[6:0] == 7'd0);
  end

  p_iso_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_type == 2'b01) |=> !hs_valid);

  p_stall_on_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (t_live && flags[t_idx]) |=> (hs_valid && hs_pid == PID_STALL));

  p_pid_legal_r3: assert property (@(posedge clk) disable iff (rst)
    hs_valid |-> (hs_pid == PID_ACK || hs_pid == PID_NAK || hs_pid == PID_STALL));

  p_ep0_selfclear_r5: assert property (@(posedge clk) disable iff (rst)
    (t_live && tx_ep == '0 && flags[0] && !cpu_ep0 && !set_ep0) |=> !flags[0]);

  p_tgl_source_r8: assert property (@(posedge clk) disable iff (rst)
    (tgl_clr != '0) |-> $past(req_valid && req_code == 2'b10));

  p_tgl_single_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tgl_clr));

  p_sts_source_r9: assert property (@(posedge clk) disable iff (rst)
    sts_valid |-> $past(req_valid && req_code == 2'b11));

  p_cpu_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && c_known) |=> (flags[$past(c_idx)] == $past(cpu_wstall)));

endmodule

bind usb_stall_ctrl usb_stall_ctrl_chk #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .cpu_wstall(cpu_wstall), .req_valid(req_valid), .req_code(req_code),
  .req_index(req_index), .sts_valid(sts_valid), .tgl_clr(tgl_clr),
  .tx_valid(tx_valid), .tx_ep(tx_ep), .tx_dir(tx_dir), .tx_type(tx_type),
  .hs_valid(hs_valid), .hs_pid(hs_pid), .flags(flags)
);

// File: tb/sim_usb_stall_ctrl.sv
`timescale 1ns/1ps
module sim_usb_stall_ctrl;

  localparam int NUM_EP = 8;
  localparam int EP_W   = 4;
  localparam int NB     = NUM_EP - 1;
  localparam int NF     = 2 * NB + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_wr = 0, cpu_wstall = 0, req_valid = 0, tx_valid = 0, tx_dir = 0, tx_ready = 0;
  logic [EP_W:0] cpu_addr = '0;
  logic [1:0] req_code = '0, tx_type = '0;
  logic [7:0] req_index = '0;
  logic [EP_W-1:0] tx_ep = '0;
  logic [7:0] cpu_rdata, sts_byte0, sts_byte1;
  logic sts_valid, hs_valid;
  logic [NB-1:0] tgl_clr;
  logic [3:0] hs_pid;

  always #10 clk = ~clk;

  usb_stall_ctrl #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u0 (.*);

  int checks = 0, errors = 0;
  bit m [NF];
  bit e_hsv, e_stsv;
  logic [3:0] e_pid;
  logic [7:0] e_rd, e_sts0;
  logic [NB-1:0] e_tgl;
  string hs_tag, rd_tag, st_tag;

  function automatic int fidx(int ep, bit dir);
    if (ep == 0) return 0;
    return dir ? NB + ep : ep;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk(hs_tag, "hs_valid", hs_valid, e_hsv);
    if (e_hsv) chk(hs_tag, "hs_pid", hs_pid, e_pid);
    else chk("R3", "hs_pid idle", hs_pid, 0);
    chk(rd_tag, "cpu_rdata", cpu_rdata, e_rd);
    chk(st_tag, "sts_valid", sts_valid, e_stsv);
    chk(st_tag, "sts_byte0", sts_byte0, e_sts0);
    chk("R9", "sts_byte1", sts_byte1, 0);
    chk("R8", "tgl_clr", tgl_clr, e_tgl);
  endtask

  task automatic step(bit cw, logic [EP_W:0] ca, bit cv, bit rv, logic [1:0] rc,
                      logic [7:0] ri, bit tv, logic [EP_W-1:0] te, bit td,
                      logic [1:0] tt, bit tr);
    bit n [NF];
    bit rk, tk, ck, autoclr;
    int ri_idx, t_idx, c_idx;
    check_outputs();
    cpu_wr = cw; cpu_addr = ca; cpu_wstall = cv;
    req_valid = rv; req_code = rc; req_index = ri;
    tx_valid = tv; tx_ep = te; tx_dir = td; tx_type = tt; tx_ready = tr;
    ck = int'(ca[EP_W-1:0]) < NUM_EP;
    c_idx = fidx(int'(ca[EP_W-1:0]), ca[EP_W]);
    rk = (ri[6:4] == 3'd0) && (int'(ri[3:0]) < NUM_EP);
    ri_idx = fidx(int'(ri[3:0]), ri[7]);
    tk = int'(te) < NUM_EP;
    t_idx = fidx(int'(te), td);
    e_rd = ck ? {7'b0, m[c_idx]} : 8'h00;
    rd_tag = "R2";
    e_hsv = tv && tk && (tt != 2'b01);
    e_pid = m[t_idx] ? 4'b1110 : (tr ? 4'b0010 : 4'b1010);
    if (tv && tt == 2'b01) hs_tag = "R4";
    else if (tv && !tk) hs_tag = "R11";
    else if (te == 0) hs_tag = "R5";
    else if (m[t_idx]) hs_tag = "R6";
    else hs_tag = "R3";
    e_stsv = rv && rc == 2'b11;
    e_sts0 = (e_stsv && rk) ? {7'b0, m[ri_idx]} : 8'h00;
    e_tgl = '0;
    if (rv && rc == 2'b10 && rk && ri[3:0] != 0) e_tgl[ri[3:0] - 1] = 1'b1;
    n = m;
    autoclr = e_hsv && (t_idx == 0) && m[0];
    if (autoclr) n[0] = 1'b0;
    if (rv && rk && rc == 2'b10) n[ri_idx] = 1'b0;
    if (rv && rk && rc == 2'b01) n[ri_idx] = 1'b1;
    if (cw && ck) n[c_idx] = cv;
    m = n;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NF; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state at the ports
    chk("R1", "hs_valid", hs_valid, 0);
    chk("R1", "hs_pid", hs_pid, 0);
    chk("R1", "sts_valid", sts_valid, 0);
    chk("R1", "sts_byte0", sts_byte0, 0);
    chk("R1", "tgl_clr", tgl_clr, 0);
    chk("R1", "cpu_rdata", cpu_rdata, 0);
    e_hsv = 0; e_pid = 0; e_rd = 0; e_stsv = 0; e_sts0 = 0; e_tgl = 0;
    hs_tag = "R1"; rd_tag = "R1"; st_tag = "R1";
    for (int f = 0; f < NF; f++) begin
      // R1: every flag reads back clear
      step(0, (f == 0) ? 5'd0 : (f > NB ? {1'b1, 4'(f - NB)} : {1'b0, 4'(f)}),
           0, 0, 0, 0, 0, 0, 0, 0, 0);
    end
    // R6: bulk IN ep3 stalled by CPU, OUT ep3 unaffected, stall persists
    step(1, 5'h13, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 5'h13, 0, 0, 0, 0, 1, 4'd3, 1, 2'b10, 1);
    step(0, 5'h03, 0, 0, 0, 0, 1, 4'd3, 1, 2'b10, 0);
    step(0, 0, 0, 0, 0, 0, 1, 4'd3, 0, 2'b10, 1);
    step(0, 0, 0, 0, 0, 0, 1, 4'd3, 1, 2'b01, 1);
    // R5: ep0 stall covers both directions, clears after one STALL
    step(1, 5'h00, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 5'h10, 0, 0, 0, 0, 1, 4'd0, 1, 2'b00, 1);
    step(0, 5'h00, 0, 0, 0, 0, 1, 4'd0, 0, 2'b00, 1);
    idle();
    // R7: set/clear halt via request; R9 status read back
    step(0, 0, 0, 1, 2'b01, 8'h05, 0, 0, 0, 0, 0);
    st_tag = "R7";
    step(0, 0, 0, 1, 2'b11, 8'h05, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 2'b11, 8'h85, 0, 0, 0, 0, 0);
    st_tag = "R9";
    // R8: clear halt pulses toggle reset for ep5
    step(0, 0, 0, 1, 2'b10, 8'h05, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 2'b11, 8'h05, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 2'b10, 8'h80, 0, 0, 0, 0, 0);
    // R7/R9: unknown index ignored and reads zero
    step(0, 0, 0, 1, 2'b01, 8'h16, 0, 0, 0, 0, 0);
    step(0, 5'h06, 0, 1, 2'b11, 8'h16, 0, 0, 0, 0, 0);
    // R10: CPU clear vs request set on IN ep2
    step(1, 5'h12, 0, 1, 2'b01, 8'h82, 0, 0, 0, 0, 0);
    rd_tag = "R10";
    step(0, 5'h12, 0, 0, 0, 0, 1, 4'd2, 1, 2'b10, 1);
    // R10: request set on ep0 beats self-clear
    step(1, 5'h00, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 2'b01, 8'h00, 1, 4'd0, 0, 2'b00, 0);
    step(0, 5'h00, 0, 0, 0, 0, 1, 4'd0, 1, 2'b00, 0);
    step(0, 5'h00, 0, 0, 0, 0, 1, 4'd9, 0, 2'b10, 1);
    // R11: unknown endpoint on transaction
    step(0, 5'h1f, 1, 0, 0, 0, 1, 4'd12, 1, 2'b10, 1);
    // random phase over all requirements
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] ri;
      ri = {1'($urandom), ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'd0,
            4'($urandom_range(0, 9))};
      step(($urandom_range(0, 5) == 0), {1'($urandom), 4'($urandom_range(0, 9))},
           1'($urandom), ($urandom_range(0, 2) == 0), 2'($urandom), ri,
           ($urandom_range(0, 3) != 0), 4'($urandom_range(0, 9)), 1'($urandom),
           2'($urandom), 1'($urandom));
    end
    idle();
    check_outputs();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule